// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches a set of external interrupt pins, up to 32 of them. Each pin passes through a two-flop synchroniser. A per-pin sense field selects what counts as an event: a low level, a high level, a falling edge, a rising edge, or either edge. An event sets a sticky detect bit for that pin. Software clears the bit by writing 1 to it.

A per-pin enable mask gates each detect bit into a request bit. Each request bit drives its own interrupt line toward the CPU through one register stage. Software reaches the block over a simple register bus with an address, write data, a write strobe, a read strobe and a registered read-data return. A monitor register lets software read the synchronised level of every pin.

Top module: `extint_ctrl`

## Requirements
- R1: After reset, every sense field, detect bit and enable bit is zero and every `irq_o` line is low.
- R2: Pin n has a sense register at byte offset 0x180 + 4·n. The register stores bits [5:0] of the write data and reads back with bits [31:6] as zero.
- R3: A pin in a level mode sets its detect bit while its synchronised level matches the mode. Sense bit 0 (code 0x01) selects low level and sense bit 1 (code 0x02) selects high level. If the level is still active after software clears the bit, the bit sets again on the next cycle.
- R4: Sense bit 3 (code 0x08) detects rising edges, sense bit 2 (code 0x04) detects falling edges, and code 0x0C detects both. Each qualifying edge sets the detect bit once. Further edges while the bit is already set add nothing, and the bit never clears on its own.
- R5: The detect status register at 0x100 (bit n = pin n) is write-1-to-clear. Writing 0 to a bit leaves it unchanged. A clear takes priority over a set in the same cycle.
- R6: Writing 1s to 0x008 sets enable bits and writing 1s to 0x004 clears them. Reading 0x004 returns the enable mask, and reading 0x008 returns zero.
- R7: The request status register at 0x000 reads as detect AND enable. `irq_o[n]` is request bit n delayed by one register.
- R8: The level monitor register at 0x104 returns the pin levels after the two-flop synchroniser.
- R9: A write to an unmapped or unaligned offset, or to a read-only register (0x000, 0x104), changes no state. A read of an unmapped offset returns zero.
- R10: A pin whose sense field is zero never sets its detect bit.
- R11: Read data appears on `bus_rdata` one cycle after `bus_rd` is sampled. `bus_rdata` is zero in any cycle that follows no read.
- R12: A pin that changes at one clock edge sets its detect bit at the third rising edge after that. With the pin enabled, the matching `irq_o` line rises at the fourth edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | NUM_PINS | Asynchronous external interrupt pins |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | NUM_PINS | Per-pin interrupt lines toward the CPU |

## Verification
A wrong detect bit, enable bit or sense field shows up at the ports within one cycle: `irq_o` is a single register stage behind detect AND enable, so it diverges from the expected mask on the next edge. A wrong internal state also shows in the next read of 0x000, 0x004, 0x100 or the sense register. A wrong synchroniser or edge-history register shifts event timing by one or more cycles. This is caught by the exact-cycle latency check and by a per-cycle model of `irq_o` that runs under random pin activity and random register traffic.

// File: rtl/extint_pkg.sv
// Shared constants for the external interrupt sense controller: register
// offsets, sense-field bit positions and the register width.
package extint_pkg;
    localparam int REG_W   = 32;
    localparam int SENSE_W = 6;

    // Sense-field bit meanings (bits are ORed; 0x0C = both edges).
    localparam int SENSE_LOW  = 0;
    localparam int SENSE_HIGH = 1;
    localparam int SENSE_FALL = 2;
    localparam int SENSE_RISE = 3;

    // Byte offsets of the register map.
    localparam int OFF_REQ    = 'h000;
    localparam int OFF_EN_CLR = 'h004;
    localparam int OFF_EN_SET = 'h008;
    localparam int OFF_DET    = 'h100;
    localparam int OFF_MON    = 'h104;
    localparam int OFF_CFG    = 'h180;

    typedef logic [SENSE_W-1:0] sense_t;
endpackage

// File: rtl/extint_sync.sv
// Two-flop synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent; no cross-bit coherence is promised.
module extint_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;

    // Capture the raw pins, then retime once more to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= async_i;
            stable_q <= meta_q;
        end
    end

    assign sync_o = stable_q;
endmodule

// File: rtl/extint_detect.sv
// Per-pin event detector with sticky status bits.
// Assumes level_i is already synchronised to clk. The sense bits are ORed,
// so any combination is legal and zero detects nothing. A clear request
// wins over a same-cycle event.
module extint_detect
    import extint_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_PINS-1:0]               level_i,
    input  logic [NUM_PINS-1:0][SENSE_W-1:0]  sense_i,
    input  logic [NUM_PINS-1:0]               clear_i,
    output logic [NUM_PINS-1:0]               detect_o
);
    logic [NUM_PINS-1:0] prev_q;
    logic [NUM_PINS-1:0] hit;
    logic [NUM_PINS-1:0] det_q;

    // Keep last cycle's synchronised level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level_i;
    end

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        // Event condition for this pin under its sense field.
        always_comb begin
            hit[g] = (sense_i[g][SENSE_LOW]  & ~level_i[g])
                   | (sense_i[g][SENSE_HIGH] &  level_i[g])
                   | (sense_i[g][SENSE_FALL] &  prev_q[g] & ~level_i[g])
                   | (sense_i[g][SENSE_RISE] & ~prev_q[g] &  level_i[g]);
        end

        // Sticky status: cleared by software, set by an event.
        always_ff @(posedge clk) begin
            if (!rst_n)          det_q[g] <= 1'b0;
            else if (clear_i[g]) det_q[g] <= 1'b0;
            else if (hit[g])     det_q[g] <= 1'b1;
        end
    end

    assign detect_o = det_q;
endmodule

// File: rtl/extint_regs.sv
// Register file and bus decode for the interrupt controller.
// Assumes single-cycle strobes and full-address decode; unaligned or
// unmapped addresses match nothing. Read data is registered and is zero in
// cycles without a read.
module extint_regs
    import extint_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 9
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [REG_W-1:0]                  bus_wdata,
    input  logic                              bus_wr,
    input  logic                              bus_rd,
    input  logic [NUM_PINS-1:0]               detect_i,
    input  logic [NUM_PINS-1:0]               request_i,
    input  logic [NUM_PINS-1:0]               level_i,
    output logic [REG_W-1:0]                  bus_rdata,
    output logic [NUM_PINS-1:0]               enable_o,
    output logic [NUM_PINS-1:0][SENSE_W-1:0]  sense_o,
    output logic [NUM_PINS-1:0]               clear_o
);
    localparam logic [ADDR_W-1:0] A_REQ    = ADDR_W'(OFF_REQ);
    localparam logic [ADDR_W-1:0] A_EN_CLR = ADDR_W'(OFF_EN_CLR);
    localparam logic [ADDR_W-1:0] A_EN_SET = ADDR_W'(OFF_EN_SET);
    localparam logic [ADDR_W-1:0] A_DET    = ADDR_W'(OFF_DET);
    localparam logic [ADDR_W-1:0] A_MON    = ADDR_W'(OFF_MON);

    logic [NUM_PINS-1:0]               cfg_sel;
    logic [NUM_PINS-1:0]               enable_q;
    logic [NUM_PINS-1:0][SENSE_W-1:0]  sense_q;
    logic [NUM_PINS-1:0]               wmask;
    logic [REG_W-1:0]                  rd_mux;
    logic [REG_W-1:0]                  rdata_q;

    assign wmask = bus_wdata[NUM_PINS-1:0];

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_cfg
        // Match this pin's sense register address.
        assign cfg_sel[g] = (bus_addr == ADDR_W'(OFF_CFG + 4 * g));

        // Hold the six sense bits; upper write bits are dropped.
        always_ff @(posedge clk) begin
            if (!rst_n)                   sense_q[g] <= '0;
            else if (bus_wr && cfg_sel[g]) sense_q[g] <= bus_wdata[SENSE_W-1:0];
        end
    end

    // Enable mask: write-1-to-set and write-1-to-clear ports.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable_q <= '0;
        else if (bus_wr && bus_addr == A_EN_SET)
            enable_q <= enable_q | wmask;
        else if (bus_wr && bus_addr == A_EN_CLR)
            enable_q <= enable_q & ~wmask;
    end

    // One-cycle clear pulse toward the detector for write-1-to-clear.
    assign clear_o = (bus_wr && bus_addr == A_DET) ? wmask : '0;

    // Select the addressed register; unmapped offsets read zero.
    always_comb begin
        rd_mux = '0;
        if (bus_addr == A_REQ)    rd_mux = REG_W'(request_i);
        if (bus_addr == A_EN_CLR) rd_mux = REG_W'(enable_q);
        if (bus_addr == A_DET)    rd_mux = REG_W'(detect_i);
        if (bus_addr == A_MON)    rd_mux = REG_W'(level_i);
        for (int p = 0; p < NUM_PINS; p++) begin
            if (cfg_sel[p]) rd_mux = REG_W'(sense_q[p]);
        end
    end

    // Register read data; zero when no read was requested.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
        else             rdata_q <= '0;
    end

    assign bus_rdata = rdata_q;
    assign enable_o  = enable_q;
    assign sense_o   = sense_q;
endmodule

// File: rtl/extint_ctrl.sv
// Top of the external interrupt sense controller.
// Chain: pins -> synchroniser -> detector -> AND enable -> output register.
// Assumes NUM_PINS <= 32 and ADDR_W wide enough to reach 0x180 + 4*(NUM_PINS-1).
module extint_ctrl
    import extint_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [REG_W-1:0]    bus_wdata,
    input  logic                bus_wr,
    input  logic                bus_rd,
    output logic [REG_W-1:0]    bus_rdata,
    output logic [NUM_PINS-1:0] irq_o
);
    logic [NUM_PINS-1:0]               level_w;
    logic [NUM_PINS-1:0]               detect_w;
    logic [NUM_PINS-1:0]               enable_w;
    logic [NUM_PINS-1:0]               clear_w;
    logic [NUM_PINS-1:0]               request_w;
    logic [NUM_PINS-1:0][SENSE_W-1:0]  sense_w;
    logic [NUM_PINS-1:0]               irq_q;

    extint_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (level_w)
    );

    extint_detect #(.NUM_PINS(NUM_PINS)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_i  (level_w),
        .sense_i  (sense_w),
        .clear_i  (clear_w),
        .detect_o (detect_w)
    );

    extint_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .detect_i  (detect_w),
        .request_i (request_w),
        .level_i   (level_w),
        .bus_rdata (bus_rdata),
        .enable_o  (enable_w),
        .sense_o   (sense_w),
        .clear_o   (clear_w)
    );

    assign request_w = detect_w & enable_w;

    // Register each request bit onto its own interrupt line.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= request_w;
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/extint_ctrl_chk.sv
// Property checker for extint_ctrl, attached by bind. It observes bus
// strobes, the detect and enable state, and the outputs.
module extint_ctrl_chk
    import extint_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 9
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [REG_W-1:0]    bus_wdata,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic [REG_W-1:0]    bus_rdata,
    input logic [NUM_PINS-1:0] irq_o,
    input logic [NUM_PINS-1:0] detect,
    input logic [NUM_PINS-1:0] enable
);
    logic det_wr, set_wr, clr_wr;
    assign det_wr = bus_wr && (bus_addr == ADDR_W'(OFF_DET));
    assign set_wr = bus_wr && (bus_addr == ADDR_W'(OFF_EN_SET));
    assign clr_wr = bus_wr && (bus_addr == ADDR_W'(OFF_EN_CLR));

    // R7
    irq_tracks_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> irq_o == $past(detect & enable));

    // R5
    detect_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(det_wr) |-> (detect & $past(bus_wdata[NUM_PINS-1:0])) == '0);

    // R4
    detect_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(det_wr) |-> ($past(detect) & ~detect) == '0);

    // R6
    enable_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(set_wr) |->
            (enable & $past(bus_wdata[NUM_PINS-1:0])) == $past(bus_wdata[NUM_PINS-1:0]));

    // R6
    enable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(clr_wr) |-> (enable & $past(bus_wdata[NUM_PINS-1:0])) == '0);

    // R11
    rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(bus_rd) |-> bus_rdata == '0);
endmodule

bind extint_ctrl extint_ctrl_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .detect    (detect_w),
    .enable    (enable_w)
);

// File: tb/extint_ctrl_bench.sv
// Self-checking bench: directed corner cases plus seeded random traffic,
// checked against a cycle model written from the requirements.
module extint_ctrl_bench;
    localparam int NP = 32;
    localparam int AW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pins = '0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic          wr = 1'b0;
    logic          rd = 1'b0;
    logic [31:0]   rdata;
    logic [NP-1:0] irq;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 0;

    always #4 clk = ~clk;

    extint_ctrl #(.NUM_PINS(NP), .ADDR_W(AW)) u_extint_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_i(pins), .bus_addr(addr),
        .bus_wdata(wdata), .bus_wr(wr), .bus_rd(rd),
        .bus_rdata(rdata), .irq_o(irq)
    );

    // ---------------- requirement model ----------------
    logic [NP-1:0] m_s1, m_s2, m_prev, m_det, m_en, m_irq, m_cond;
    logic [5:0]    m_cfg [NP];
    logic [31:0]   m_rd;

    function automatic logic [31:0] rd_model(input logic [AW-1:0] a);
        if (a == 9'h000) return m_det & m_en;
        if (a == 9'h004) return m_en;
        if (a == 9'h100) return m_det;
        if (a == 9'h104) return m_s2;
        if (a >= 9'h180 && a[1:0] == 2'b00) return {26'b0, m_cfg[a[6:2]]};
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_det <= '0;
            m_en <= '0; m_irq <= '0; m_rd <= '0;
            for (int i = 0; i < NP; i++) m_cfg[i] <= '0;
        end else begin
            for (int i = 0; i < NP; i++)
                m_cond[i] = (m_cfg[i][0] && !m_s2[i]) || (m_cfg[i][1] && m_s2[i]) ||
                            (m_cfg[i][2] && m_prev[i] && !m_s2[i]) ||
                            (m_cfg[i][3] && !m_prev[i] && m_s2[i]);
            m_s1 <= pins; m_s2 <= m_s1; m_prev <= m_s2;
            if (wr && addr == 9'h100) m_det <= (m_det | m_cond) & ~wdata;
            else                      m_det <= m_det | m_cond;
            if (wr && addr == 9'h008) m_en <= m_en | wdata;
            if (wr && addr == 9'h004) m_en <= m_en & ~wdata;
            if (wr && addr >= 9'h180 && addr[1:0] == 2'b00) m_cfg[addr[6:2]] <= wdata[5:0];
            m_irq <= m_det & m_en;
            m_rd  <= rd ? rd_model(addr) : 32'h0;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // R7 R11: every cycle, outputs match the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R7 irq_o vs model", irq, m_irq);
            check("R11 rdata vs model", rdata, m_rd);
        end
    end

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0; wdata = '0;
    endtask

    // imm=1: start in the current negedge slot (right after a write).
    task automatic bus_read(input logic [AW-1:0] a, input bit imm, output logic [31:0] d);
        if (!imm) @(negedge clk);
        addr = a; rd = 1'b1;
        @(negedge clk); rd = 1'b0; d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            finish_run();
        end
    end

    logic [31:0] r;

    initial begin
        void'($urandom(32'h0000_5EED));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        check("R1 irq after reset", irq, 0);
        bus_read(9'h004, 0, r); check("R1 enable after reset", r, 0);
        bus_read(9'h100, 0, r); check("R1 detect after reset", r, 0);
        bus_read(9'h180, 0, r); check("R1 sense after reset", r, 0);

        // R2 sense register width
        bus_write(9'h18C, 32'hFFFF_FFFF);
        bus_read(9'h18C, 0, r); check("R2 sense keeps six bits", r, 32'h3F);
        bus_write(9'h18C, 32'h02);
        bus_read(9'h18C, 0, r); check("R2 sense rewrite", r, 32'h02);
        bus_write(9'h100, 32'hFFFF_FFFF);

        // R3 high level on pin 3, re-set after clear
        pins[3] = 1'b1; idle(4);
        bus_read(9'h100, 0, r); check("R3 high level detect", r, 32'h8);
        bus_write(9'h100, 32'h8);
        bus_read(9'h100, 1, r); check("R3 cleared for one cycle", r, 32'h0);
        bus_read(9'h100, 1, r); check("R3 re-set while level held", r, 32'h8);
        pins[3] = 1'b0; idle(4);
        bus_write(9'h100, 32'h8);
        bus_read(9'h100, 0, r); check("R3 stays clear after level drops", r, 32'h0);
        // low level on pin 4
        bus_write(9'h190, 32'h01); idle(2);
        bus_read(9'h100, 0, r); check("R3 low level detect", r, 32'h10);
        pins[4] = 1'b1; idle(4);
        bus_write(9'h100, 32'h10);
        bus_read(9'h100, 0, r); check("R3 low level released", r, 32'h0);

        // R4 rising on pin 5
        bus_write(9'h194, 32'h08);
        pins[5] = 1'b1; idle(4);
        bus_read(9'h100, 0, r); check("R4 rising edge", r, 32'h20);
        bus_write(9'h100, 32'h20); idle(4);
        bus_read(9'h100, 0, r); check("R4 no re-set on held high", r, 32'h0);
        pins[5] = 1'b0; idle(4);
        bus_read(9'h100, 0, r); check("R4 rising ignores fall", r, 32'h0);
        pins[5] = 1'b1; idle(2); pins[5] = 1'b0; idle(2); pins[5] = 1'b1; idle(4);
        bus_write(9'h100, 32'h20); idle(3);
        bus_read(9'h100, 0, r); check("R4 edges while set add nothing", r, 32'h0);
        // both edges on pin 6
        bus_write(9'h198, 32'h0C);
        pins[6] = 1'b1; idle(4);
        bus_read(9'h100, 0, r); check("R4 both: rise", r, 32'h40);
        bus_write(9'h100, 32'h40);
        pins[6] = 1'b0; idle(4);
        bus_read(9'h100, 0, r); check("R4 both: fall", r, 32'h40);
        bus_write(9'h100, 32'h40);
        // falling on pin 7
        bus_write(9'h19C, 32'h04);
        pins[7] = 1'b1; idle(4);
        bus_read(9'h100, 0, r); check("R4 falling ignores rise", r, 32'h0);
        pins[7] = 1'b0; idle(4);
        bus_read(9'h100, 0, r); check("R4 falling edge", r, 32'h80);
        bus_write(9'h100, 32'h80);

        // R5 write 0 leaves bit set
        pins[3] = 1'b1; idle(4);
        bus_write(9'h100, 32'hFFFF_FFF7);
        bus_read(9'h100, 0, r); check("R5 write 0 keeps bit", r, 32'h8);

        // R6 enable set / clear
        bus_write(9'h008, 32'h0000_0108);
        bus_read(9'h004, 0, r); check("R6 enable set", r, 32'h108);
        bus_read(9'h008, 0, r); check("R6 set register reads zero", r, 32'h0);
        bus_write(9'h004, 32'h100);
        bus_read(9'h004, 0, r); check("R6 enable clear", r, 32'h8);

        // R7 request and irq line
        idle(2);
        check("R7 irq line for pin 3", irq, 32'h8);
        bus_read(9'h000, 0, r); check("R7 request status", r, 32'h8);
        bus_write(9'h004, 32'h8); idle(2);
        check("R7 irq drops when disabled", irq, 32'h0);

        // R8 monitor
        pins = 32'hA5A5_0018; idle(3);
        bus_read(9'h104, 0, r); check("R8 level monitor", r, 32'hA5A5_0018);

        // R9 unmapped / read-only writes
        bus_write(9'h00C, 32'hFFFF_FFFF);
        bus_read(9'h00C, 0, r); check("R9 unmapped read zero", r, 32'h0);
        bus_write(9'h000, 32'hFFFF_FFFF);
        bus_write(9'h104, 32'hFFFF_FFFF);
        bus_read(9'h004, 0, r); check("R9 read-only writes ignored", r, 32'h0);
        bus_write(9'h181, 32'h3F);
        bus_read(9'h180, 0, r); check("R9 unaligned write ignored", r, 32'h0);
        bus_read(9'h181, 0, r); check("R9 unaligned read zero", r, 32'h0);

        // R10 zero sense field on pin 9
        bus_write(9'h100, 32'hFFFF_FFFF);
        pins[9] = 1'b1; idle(3); pins[9] = 1'b0; idle(3);
        bus_read(9'h100, 0, r); check("R10 zero sense detects nothing", r & 32'h200, 32'h0);

        // R11 idle read data
        idle(1);
        check("R11 rdata zero without read", rdata, 32'h0);

        // R12 latency on pin 10
        pins[10] = 1'b0;
        bus_write(9'h1A8, 32'h02);
        bus_write(9'h008, 32'h400);
        idle(3);
        pins[10] = 1'b1;
        idle(3);
        check("R12 irq low after third edge", irq & 32'h400, 32'h0);
        idle(1);
        check("R12 irq high at fourth edge", irq & 32'h400, 32'h400);

        // Random phase
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            wr = 1'b0; rd = 1'b0;
            if ($urandom % 4 == 0) pins = pins ^ (32'h1 << ($urandom % NP));
            case ($urandom % 8)
                0: begin
                    addr = 9'h180 + 9'(4 * ($urandom % NP));
                    case ($urandom % 6)
                        0: wdata = 32'h00; 1: wdata = 32'h01; 2: wdata = 32'h02;
                        3: wdata = 32'h04; 4: wdata = 32'h08; default: wdata = 32'h0C;
                    endcase
                    wr = 1'b1;
                end
                1: begin addr = 9'h100; wdata = $urandom; wr = 1'b1; end
                2: begin addr = 9'h008; wdata = $urandom; wr = 1'b1; end
                3: begin addr = 9'h004; wdata = $urandom; wr = 1'b1; end
                4: begin
                    case ($urandom % 5)
                        0: addr = 9'h000; 1: addr = 9'h004; 2: addr = 9'h100;
                        3: addr = 9'h104; default: addr = 9'h180 + 9'(4 * ($urandom % NP));
                    endcase
                    rd = 1'b1;
                end
                default: ;
            endcase
        end
        @(negedge clk); wr = 1'b0; rd = 1'b0;
        idle(2);
        finish_run();
    end
endmodule